// File: doc/BRIEF.md
# Packed Byte/Word SIMD Unit

This block is a small integer SIMD datapath. It works on packed data held in ordinary 64-bit integer registers, so it needs no separate vector register file. Each operation takes a 4-bit operation code and two 64-bit operands, A and B, and produces one 64-bit result. The operations are:

- lane-wise maximum and minimum, signed or unsigned, over eight byte lanes or four 16-bit lanes;
- a sum of absolute byte differences, for motion-estimation style pixel error;
- packing, which narrows words or longwords to bytes;
- unpacking, which widens bytes to words or longwords.

Lane N always means bits [W*N+W-1 : W*N] for a lane width W. The result is registered, so it appears one clock after the request, together with a valid strobe.

Top module: `psimd_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, out_valid is 0 and out_data is all zeros.
- R2: A request presented with in_valid high at a clock edge has its result on out_data, and out_valid high, after that edge. A cycle with in_valid low drives out_valid low after the edge and leaves out_data unchanged.
- R3: Byte max/min uses op codes 0 (signed max), 1 (unsigned max), 4 (signed min) and 5 (unsigned min). Each of the eight result bytes is the larger (max) or smaller (min) of the matching A and B bytes, compared in two's complement or unsigned form.
- R4: Word max/min uses op codes 2 (signed max), 3 (unsigned max), 6 (signed min) and 7 (unsigned min). These apply the same rule as R3 to four 16-bit lanes.
- R5: Op code 8 returns the sum over all eight byte positions of |A byte − B byte|, with both bytes taken as unsigned. The sum is zero-extended to 64 bits.
- R6: Op code 9 (pack words) sets result byte i to the low byte of 16-bit lane i of B, for i = 0..3. Result bytes 7..4 are zero.
- R7: Op code 10 (pack longwords) sets result byte i to the low byte of 32-bit lane i of B, for i = 0..1. Result bytes 7..2 are zero.
- R8: Op code 11 (unpack to words) sets 16-bit lane i to B byte i, zero-extended, for i = 0..3.
- R9: Op code 12 (unpack to longwords) sets 32-bit lane i to B byte i, zero-extended, for i = 0..1.
- R10: For op codes 9 to 12 the result does not depend on operand A.
- R11: Op codes 13, 14 and 15 produce an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 4 | Operation code |
| opnd_a | input | 64 | First operand (A) |
| opnd_b | input | 64 | Second operand (B) |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_data | output | 64 | Registered result |

## Verification
Every result, whatever the operation, is due exactly one clock after the edge that captured in_valid. There is a single output register and no per-operation latency. The bench drives each request on a falling edge and checks the result on the next falling edge, half a period after the capturing rising edge, so there is no race with the clock. Idle cycles are checked in the same way: after each one the bench confirms that out_valid has dropped and out_data still holds the previous result.

// File: rtl/psimd_pkg.sv
package psimd_pkg;

   typedef enum logic [3:0] {
      OP_MAXS_B = 4'd0,
      OP_MAXU_B = 4'd1,
      OP_MAXS_W = 4'd2,
      OP_MAXU_W = 4'd3,
      OP_MINS_B = 4'd4,
      OP_MINU_B = 4'd5,
      OP_MINS_W = 4'd6,
      OP_MINU_W = 4'd7,
      OP_SAD    = 4'd8,
      OP_PACK_W = 4'd9,
      OP_PACK_L = 4'd10,
      OP_UNPK_W = 4'd11,
      OP_UNPK_L = 4'd12
   } psimd_op_e;

   typedef enum logic [1:0] {
      MV_PACK_W = 2'd0,
      MV_PACK_L = 2'd1,
      MV_UNPK_W = 2'd2,
      MV_UNPK_L = 2'd3
   } psimd_mv_e;

endpackage

// File: rtl/psimd_minmax.sv
module psimd_minmax #(
   parameter int DATA_W = 64,
   parameter int LANE_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              is_unsigned,
   input  logic              take_min,
   output logic [DATA_W-1:0] y
);
   localparam int NUM_LANES = DATA_W / LANE_W;

   generate
      if (DATA_W % LANE_W != 0 || LANE_W < 2) begin : g_bad_cfg
         $error("psimd_minmax: DATA_W must be a multiple of LANE_W");
      end
      for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
         logic [LANE_W-1:0] la, lb, pick;
         logic              a_gt;
         assign la = a[i*LANE_W +: LANE_W];
         assign lb = b[i*LANE_W +: LANE_W];
         always_comb begin
            if (is_unsigned) a_gt = la > lb;
            else             a_gt = $signed(la) > $signed(lb);
            pick = (a_gt ^ take_min) ? la : lb;
         end
         assign y[i*LANE_W +: LANE_W] = pick;
      end
   endgenerate
endmodule

// File: rtl/psimd_sad.sv
module psimd_sad #(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);
   localparam int NUM_B = DATA_W / 8;
   localparam int SUM_W = $clog2(NUM_B * 255 + 1);

   generate
      if (SUM_W > DATA_W) begin : g_bad_cfg
         $error("psimd_sad: sum does not fit the result");
      end
   endgenerate

   logic [SUM_W-1:0] sum;

   always_comb begin
      sum = '0;
      for (int i = 0; i < NUM_B; i++) begin
         logic [7:0] xa, xb, d;
         xa = a[i*8 +: 8];
         xb = b[i*8 +: 8];
         d  = (xa > xb) ? (xa - xb) : (xb - xa);
         sum = sum + SUM_W'(d);
      end
      y = DATA_W'(sum);
   end
endmodule

// File: rtl/psimd_pack.sv
module psimd_pack
   import psimd_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] b,
   input  psimd_mv_e         mode,
   output logic [DATA_W-1:0] y
);
   localparam int NUM_W = DATA_W / 16;
   localparam int NUM_L = DATA_W / 32;

   always_comb begin
      y = '0;
      unique case (mode)
         MV_PACK_W: for (int i = 0; i < NUM_W; i++) y[i*8 +: 8]  = b[i*16 +: 8];
         MV_PACK_L: for (int i = 0; i < NUM_L; i++) y[i*8 +: 8]  = b[i*32 +: 8];
         MV_UNPK_W: for (int i = 0; i < NUM_W; i++) y[i*16 +: 8] = b[i*8 +: 8];
         MV_UNPK_L: for (int i = 0; i < NUM_L; i++) y[i*32 +: 8] = b[i*8 +: 8];
      endcase
   end
endmodule

// File: rtl/psimd_unit.sv
module psimd_unit
   import psimd_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [3:0]        op_sel,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);
   generate
      if (DATA_W % 32 != 0 || DATA_W < 32) begin : g_bad_cfg
         $error("psimd_unit: DATA_W must be a nonzero multiple of 32");
      end
   endgenerate

   logic [DATA_W-1:0] mm_b, mm_w, sad_y, mv_y, res;
   logic [3:0]        mv_idx;
   psimd_op_e         op;

   assign op     = psimd_op_e'(op_sel);
   assign mv_idx = op_sel - 4'd9;

   psimd_minmax #(.DATA_W(DATA_W), .LANE_W(8)) u_mm_b (
      .a(opnd_a), .b(opnd_b), .is_unsigned(op_sel[0]),
      .take_min(op_sel[2]), .y(mm_b));

   psimd_minmax #(.DATA_W(DATA_W), .LANE_W(16)) u_mm_w (
      .a(opnd_a), .b(opnd_b), .is_unsigned(op_sel[0]),
      .take_min(op_sel[2]), .y(mm_w));

   psimd_sad #(.DATA_W(DATA_W)) u_sad (
      .a(opnd_a), .b(opnd_b), .y(sad_y));

   psimd_pack #(.DATA_W(DATA_W)) u_pack (
      .b(opnd_b), .mode(psimd_mv_e'(mv_idx[1:0])), .y(mv_y));

   always_comb begin
      case (op)
         OP_MAXS_B, OP_MAXU_B, OP_MINS_B, OP_MINU_B: res = mm_b;
         OP_MAXS_W, OP_MAXU_W, OP_MINS_W, OP_MINU_W: res = mm_w;
         OP_SAD:                                     res = sad_y;
         OP_PACK_W, OP_PACK_L, OP_UNPK_W, OP_UNPK_L: res = mv_y;
         default:                                    res = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_data <= res;
      end
   end

   // R1: outputs cleared while reset is held
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         p_reset_clear_r1: assert (out_valid == 1'b0 && out_data == '0);
      end
   end

   p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_data)));

   p_maxub_lane0_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == OP_MAXU_B) |=>
         (out_data[7:0] >= $past(opnd_a[7:0]) && out_data[7:0] >= $past(opnd_b[7:0])));

   p_minuw_lane0_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == OP_MINU_W) |=>
         (out_data[15:0] <= $past(opnd_a[15:0]) && out_data[15:0] <= $past(opnd_b[15:0])));

   p_sad_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == OP_SAD) |=> (out_data[DATA_W-1:12] == '0));

   p_packw_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == OP_PACK_W) |=> (out_data[DATA_W-1:DATA_W/2] == '0));

   p_unknown_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel > 4'd12) |=> (out_data == '0));
endmodule

// File: tb/psimd_unit_test.sv
`timescale 1ns/1ps
module psimd_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  op_sel = 4'd0;
   logic [63:0] opnd_a = 64'd0;
   logic [63:0] opnd_b = 64'd0;
   logic        out_valid;
   logic [63:0] out_data;

   int checks = 0;
   int errors = 0;
   logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

   always #2 clk = ~clk;

   psimd_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid), .out_data(out_data));

   function automatic logic [63:0] model(int op, logic [63:0] a, logic [63:0] b);
      logic [63:0] r;
      r = 64'd0;
      if (op < 8) begin
         int lw;
         logic [63:0] mask, sbit;
         lw   = ((op & 2) != 0) ? 16 : 8;
         mask = (64'd1 << lw) - 64'd1;
         sbit = 64'd1 << (lw - 1);
         for (int i = 0; i < 64 / lw; i++) begin
            logic [63:0] x, y, kx, ky;
            logic        sel_x;
            x  = (a >> (i * lw)) & mask;
            y  = (b >> (i * lw)) & mask;
            kx = x; ky = y;
            if ((op & 1) == 0) begin
               kx = kx ^ sbit;
               ky = ky ^ sbit;
            end
            sel_x = ((op & 4) != 0) ? (kx < ky) : (kx > ky);
            r = r | ((sel_x ? x : y) << (i * lw));
         end
      end else if (op == 8) begin
         for (int i = 0; i < 8; i++) begin
            int xa, xb;
            xa = int'((a >> (8 * i)) & 64'hFF);
            xb = int'((b >> (8 * i)) & 64'hFF);
            r = r + 64'((xa > xb) ? xa - xb : xb - xa);
         end
      end else if (op == 9) begin
         for (int i = 0; i < 4; i++) r = r | (((b >> (16 * i)) & 64'hFF) << (8 * i));
      end else if (op == 10) begin
         for (int i = 0; i < 2; i++) r = r | (((b >> (32 * i)) & 64'hFF) << (8 * i));
      end else if (op == 11) begin
         for (int i = 0; i < 4; i++) r = r | (((b >> (8 * i)) & 64'hFF) << (16 * i));
      end else if (op == 12) begin
         for (int i = 0; i < 2; i++) r = r | (((b >> (8 * i)) & 64'hFF) << (32 * i));
      end
      return r;
   endfunction

   function automatic string tag(int op);
      if (op < 8)   return ((op & 2) != 0) ? "R4" : "R3";
      if (op == 8)  return "R5";
      if (op == 9)  return "R6";
      if (op == 10) return "R7";
      if (op == 11) return "R8";
      if (op == 12) return "R9";
      return "R11";
   endfunction

   function automatic logic [63:0] next_rand(logic [63:0] s);
      logic [63:0] t;
      t = s ^ (s << 13);
      t = t ^ (t >> 7);
      t = t ^ (t << 17);
      return t;
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic apply(int op, logic [63:0] a, logic [63:0] b, string req);
      in_valid = 1'b1;
      op_sel   = 4'(op);
      opnd_a   = a;
      opnd_b   = b;
      @(negedge clk);
      check({req, " (R2 out_valid)"}, {63'd0, out_valid}, 64'd1);
      check(req, out_data, model(op, a, b));
   endtask

   task automatic idle(logic [63:0] a, logic [63:0] b);
      logic [63:0] prev;
      prev     = out_data;
      in_valid = 1'b0;
      op_sel   = 4'd8;
      opnd_a   = a;
      opnd_b   = b;
      @(negedge clk);
      check("R2 idle out_valid", {63'd0, out_valid}, 64'd0);
      check("R2 idle hold", out_data, prev);
   endtask

   task automatic sweep(logic [63:0] a, logic [63:0] b);
      for (int op = 0; op < 16; op++) begin
         apply(op, a, b, tag(op));
         if (op >= 9 && op <= 12) apply(op, ~a, b, {tag(op), " R10 A ignored"});
      end
      idle(~a, ~b);
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset valid", {63'd0, out_valid}, 64'd0);
      check("R1 reset data", out_data, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 post-reset valid", {63'd0, out_valid}, 64'd0);
      check("R1 post-reset data", out_data, 64'd0);

      sweep(64'h0, 64'h0);
      sweep(64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
      sweep(64'h8080_8080_8080_8080, 64'h7F7F_7F7F_7F7F_7F7F);
      sweep(64'h8000_7FFF_0001_FFFF, 64'h7FFF_8000_FFFF_0001);
      sweep(64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF);
      sweep(64'h00FF_00FF_00FF_00FF, 64'hFF00_FF00_FF00_FF00);
      for (int v = 0; v < 60; v++) begin
         logic [63:0] ra, rb;
         seed = next_rand(seed);
         ra   = seed;
         seed = next_rand(seed);
         rb   = seed;
         sweep(ra, rb);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule